// File: doc/BRIEF.md
# Selectable Output Divider with Test Selector

This block is the digital back end of a clock synthesizer. A fast source clock is divided down by a ratio chosen with a 2-bit code to form the synthesizer output. A crystal clock is divided by eight to form the phase-detector reference. A 9-bit feedback counter divides the source by M and marks each wrap with a pulse. A test output picks one of eight internal or constant signals with a 3-bit select. The phase-locked loop itself is outside the block.

Everything runs in one system clock domain. Each incoming clock is modelled as a stream of edge marks: `vco_edge` and `xtal_edge` are one-cycle strobes, and each strobe stands for one edge of the modelled clock, of either polarity. The shift clock arrives as a level. Every change of that level counts as one of its edges.

A small source-select state machine has two states, `ST_OSC` and `ST_BYPASS`. Transition ENTER_BYPASS is taken when the test select equals 110. Transition LEAVE_BYPASS is taken when it holds any other value. In `ST_OSC` the VCO edge marks feed the output divider and the feedback counter. In `ST_BYPASS` the edges of the shift clock feed them instead. Because the counters only advance on edge marks, switching the source never produces a partial pulse.

Top module: `synth_out_divider`

## Requirements
- R1: While `rst_n` is low, `fout`, `fref` and `fb_pulse` are 0. With `t_sel` = 000, `test_out` then follows `sr_last`.
- R2: The output divider toggles `fout` every 2, 4, 8 or 1 source edges for `n_sel` codes 00, 01, 10 and 11. Both halves of each output period are equal, which gives a 50% duty cycle at every ratio.
- R3: A new `n_sel` value is taken only when `fout` toggles. A half period already under way completes at the old ratio.
- R4: `fref` toggles every 8 `xtal_edge` marks, so it runs at the crystal frequency divided by 8.
- R5: `fb_pulse` is high for exactly one system cycle, once every M rising source edges. A rising source edge is every second source edge. M is read from `m_div` at each reload, and an M of 0 behaves as 1.
- R6: `test_out` selects by `t_sel` as follows: 000 `sr_last`, 001 constant 1, 010 `fref`, 011 `fb_pulse`, 100 `fout`, 101 constant 0.
- R7: `t_sel` = 110 selects bypass one system cycle after it is presented. In bypass, each change of `shift_clk` is a source edge, `vco_edge` has no effect, and `test_out` carries `fb_pulse`, which is the shift clock divided by M.
- R8: Outside bypass, changes of `shift_clk` do not move `fout`.
- R9: With `t_sel` = 111, `test_out` is `fout` divided by 4. It toggles once every 2 rising edges of `fout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_edge | input | 1 | One mark per edge of the modelled VCO clock |
| xtal_edge | input | 1 | One mark per edge of the modelled crystal clock |
| shift_clk | input | 1 | Shift clock level, used as the source in bypass |
| m_div | input | 9 | Feedback divide value M |
| n_sel | input | 2 | Output ratio code |
| t_sel | input | 3 | Test output select code |
| sr_last | input | 1 | Last bit of the configuration shift register |
| fout | output | 1 | Divided synthesizer output |
| fref | output | 1 | Crystal divided by 8 |
| fb_pulse | output | 1 | Feedback counter wrap pulse |
| test_out | output | 1 | Selected test signal |

## Verification
Two situations are hardest to reach from the ports: a ratio change in the middle of a half period, and a source switch in the very cycle that a shift-clock edge arrives.

For the ratio change, the stimulus first runs source edges until `fout` toggles, so the position within the half period is known. It then applies three more edges and changes `n_sel`. It counts the remaining edges of the old half period and then the length of the next one.

For the source switch, the bench presents `t_sel` = 110 together with a `shift_clk` change. It checks that this edge is lost, that the following edge is counted, and that a VCO mark in bypass leaves `fout` still.

// File: rtl/sod_pkg.sv
package sod_pkg;

    typedef enum logic {
        ST_OSC    = 1'b0,
        ST_BYPASS = 1'b1
    } src_state_t;

    localparam int RATIO_W = 4;

    localparam logic [2:0] T_SRLAST  = 3'b000;
    localparam logic [2:0] T_HIGH    = 3'b001;
    localparam logic [2:0] T_FREF    = 3'b010;
    localparam logic [2:0] T_FB      = 3'b011;
    localparam logic [2:0] T_FOUT    = 3'b100;
    localparam logic [2:0] T_LOW     = 3'b101;
    localparam logic [2:0] T_BYPASS  = 3'b110;
    localparam logic [2:0] T_QUARTER = 3'b111;

    // Source edges per output half period for each ratio code.
    function automatic logic [RATIO_W-1:0] half_edges(input logic [1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            2'b00:   r = RATIO_W'(2);
            2'b01:   r = RATIO_W'(4);
            2'b10:   r = RATIO_W'(8);
            default: r = RATIO_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sod_out_div.sv
module sod_out_div
    import sod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] n_code,
    output logic       div_out
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] half_q;

    // The ratio is reloaded only at a toggle, so a half period never shortens.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            half_q  <= half_edges(2'b00);
            div_out <= 1'b0;
        end else if (tick) begin
            if (cnt_q == half_q - 1'b1) begin
                cnt_q   <= '0;
                half_q  <= half_edges(n_code);
                div_out <= ~div_out;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sod_edge_div.sv
module sod_edge_div #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic div_out
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            div_out <= 1'b0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cnt_q   <= '0;
                div_out <= ~div_out;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sod_fb_div.sv
module sod_fb_div #(
    parameter int MW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic [MW-1:0] m_val,
    output logic          pulse
);

    logic [MW-1:0] cnt_q;
    logic [MW-1:0] load_val;

    always_comb load_val = (m_val == '0) ? MW'(1) : m_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (rise) begin
                if (cnt_q <= MW'(1)) begin
                    cnt_q <= load_val;
                    pulse <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/synth_out_divider.sv
module synth_out_divider
    import sod_pkg::*;
#(
    parameter int M_W      = 9,
    parameter int REF_HALF = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_edge,
    input  logic           xtal_edge,
    input  logic           shift_clk,
    input  logic [M_W-1:0] m_div,
    input  logic [1:0]     n_sel,
    input  logic [2:0]     t_sel,
    input  logic           sr_last,
    output logic           fout,
    output logic           fref,
    output logic           fb_pulse,
    output logic           test_out
);

    src_state_t state_q, state_d;
    logic       sclk_q;
    logic       sh_edge;
    logic       src_tick;
    logic       src_phase_q;
    logic       rise_tick;
    logic       fout_prev_q;
    logic [1:0] quart_q;

    assign sh_edge   = shift_clk ^ sclk_q;
    assign rise_tick = src_tick & ~src_phase_q;

    // Next state: ENTER_BYPASS on code 110, LEAVE_BYPASS otherwise.
    always_comb begin
        state_d = (t_sel == T_BYPASS) ? ST_BYPASS : ST_OSC;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OSC;
        else        state_q <= state_d;
    end

    // Outputs of the state machine: which edge stream feeds the dividers.
    always_comb begin
        unique case (state_q)
            ST_OSC:    src_tick = vco_edge;
            ST_BYPASS: src_tick = sh_edge;
            default:   src_tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q      <= 1'b0;
            src_phase_q <= 1'b0;
            fout_prev_q <= 1'b0;
            quart_q     <= '0;
        end else begin
            sclk_q      <= shift_clk;
            fout_prev_q <= fout;
            if (src_tick)             src_phase_q <= ~src_phase_q;
            if (fout && !fout_prev_q) quart_q     <= quart_q + 1'b1;
        end
    end

    sod_out_div u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (src_tick),
        .n_code  (n_sel),
        .div_out (fout)
    );

    sod_edge_div #(.HALF(REF_HALF)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (xtal_edge),
        .div_out (fref)
    );

    sod_fb_div #(.MW(M_W)) u_fb (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise_tick),
        .m_val (m_div),
        .pulse (fb_pulse)
    );

    always_comb begin
        unique case (t_sel)
            T_SRLAST:  test_out = sr_last;
            T_HIGH:    test_out = 1'b1;
            T_FREF:    test_out = fref;
            T_FB:      test_out = fb_pulse;
            T_FOUT:    test_out = fout;
            T_LOW:     test_out = 1'b0;
            T_BYPASS:  test_out = fb_pulse;
            T_QUARTER: test_out = quart_q[1];
            default:   test_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/synth_out_divider_chk.sv
module synth_out_divider_chk #(
    parameter int M_W = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           vco_edge,
    input logic           xtal_edge,
    input logic           sh_edge,
    input logic           src_tick,
    input logic           in_byp,
    input logic [M_W-1:0] m_div,
    input logic           fout,
    input logic           fref,
    input logic           fb_pulse
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_quiet_chk: assert (!fout && !fref && !fb_pulse);
        end
    end

    // R2
    fout_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fout) |-> $past(src_tick));

    // R4
    fref_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fref) |-> $past(xtal_edge));

    // R5
    fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && ($past(m_div) >= M_W'(2))) |=> !fb_pulse);

    // R7
    byp_vco_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byp && vco_edge && !sh_edge) |=> $stable(fout));

endmodule

bind synth_out_divider synth_out_divider_chk #(.M_W(M_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vco_edge  (vco_edge),
    .xtal_edge (xtal_edge),
    .sh_edge   (sh_edge),
    .src_tick  (src_tick),
    .in_byp    (state_q == sod_pkg::ST_BYPASS),
    .m_div     (m_div),
    .fout      (fout),
    .fref      (fref),
    .fb_pulse  (fb_pulse)
);

// File: tb/synth_out_divider_test.sv
`timescale 1ns/1ps
module synth_out_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vco_edge = 1'b0;
    logic       xtal_edge = 1'b0;
    logic       shift_clk = 1'b0;
    logic [8:0] m_div = 9'd4;
    logic [1:0] n_sel = 2'b00;
    logic [2:0] t_sel = 3'b000;
    logic       sr_last = 1'b0;
    logic       fout, fref, fb_pulse, test_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    synth_out_divider uut (
        .clk(clk), .rst_n(rst_n), .vco_edge(vco_edge), .xtal_edge(xtal_edge),
        .shift_clk(shift_clk), .m_div(m_div), .n_sel(n_sel), .t_sel(t_sel),
        .sr_last(sr_last), .fout(fout), .fref(fref), .fb_pulse(fb_pulse),
        .test_out(test_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One system cycle: inputs change at the falling edge, results read 1 ns after the rising edge.
    task automatic cyc(input logic v, input logic x, input logic s);
        @(negedge clk);
        vco_edge  = v;
        xtal_edge = x;
        if (s) shift_clk = ~shift_clk;
        @(posedge clk);
        #1;
    endtask

    task automatic until_fout(input bit use_shift, output int n);
        logic f0;
        f0 = fout;
        n  = 0;
        do begin
            cyc(!use_shift, 1'b0, use_shift);
            n++;
        end while (fout == f0 && n < 64);
    endtask

    task automatic until_test(input bit use_shift, output int n);
        n = 0;
        do begin
            cyc(!use_shift, 1'b0, use_shift);
            n++;
        end while (!test_out && n < 2100);
    endtask

    task automatic t_reset;
        cyc(1'b1, 1'b1, 1'b1);
        chk(!fout && !fref && !fb_pulse, "R1 outputs low in reset", {fout, fref, fb_pulse}, 0);
        sr_last = 1'b1;
        #1;
        chk(test_out == 1'b1, "R1 test follows sr_last", test_out, 1);
        sr_last = 1'b0;
        #1;
        chk(test_out == 1'b0, "R1 test follows sr_last low", test_out, 0);
        @(negedge clk);
        vco_edge = 1'b0; xtal_edge = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_ratio(input logic [1:0] code, input int exp);
        int n;
        n_sel = code;
        until_fout(1'b0, n);
        until_fout(1'b0, n);
        until_fout(1'b0, n);
        chk(n == exp, $sformatf("R2 code %b first half", code), n, exp);
        until_fout(1'b0, n);
        chk(n == exp, $sformatf("R2 code %b second half", code), n, exp);
    endtask

    task automatic t_midchange;
        int n;
        n_sel = 2'b10;
        until_fout(1'b0, n);
        until_fout(1'b0, n);
        repeat (3) cyc(1'b1, 1'b0, 1'b0);
        n_sel = 2'b11;
        until_fout(1'b0, n);
        chk(n == 5, "R3 old ratio completes", n, 5);
        until_fout(1'b0, n);
        chk(n == 1, "R3 new ratio after toggle", n, 1);
    endtask

    task automatic t_fref;
        int n;
        logic f0;
        for (int k = 0; k < 2; k++) begin
            f0 = fref;
            n = 0;
            do begin cyc(1'b0, 1'b1, 1'b0); n++; end while (fref == f0 && n < 64);
            if (k == 1) chk(n == 8, "R4 crystal edges per fref half", n, 8);
        end
        f0 = fref;
        repeat (5) cyc(1'b1, 1'b0, 1'b0);
        chk(fref == f0, "R4 fref still without crystal edges", fref, f0);
    endtask

    task automatic t_fb(input logic [8:0] m, input int exp);
        int n;
        t_sel = 3'b011;
        m_div = m;
        until_test(1'b0, n);
        until_test(1'b0, n);
        cyc(1'b1, 1'b0, 1'b0);
        chk(!fb_pulse, $sformatf("R5 pulse one cycle M=%0d", m), fb_pulse, 0);
        n = 1;
        do begin cyc(1'b1, 1'b0, 1'b0); n++; end while (!fb_pulse && n < 2100);
        chk(n == exp, $sformatf("R5 edges between pulses M=%0d", m), n, exp);
    endtask

    task automatic t_mux;
        bit ok;
        t_sel = 3'b001; cyc(1'b1, 1'b0, 1'b0);
        chk(test_out == 1'b1, "R6 code 001 high", test_out, 1);
        t_sel = 3'b101; cyc(1'b1, 1'b0, 1'b0);
        chk(test_out == 1'b0, "R6 code 101 low", test_out, 0);
        t_sel = 3'b000; sr_last = 1'b1; cyc(1'b0, 1'b0, 1'b0);
        chk(test_out == 1'b1, "R6 code 000 sr_last", test_out, 1);
        sr_last = 1'b0;
        t_sel = 3'b010; ok = 1;
        for (int k = 0; k < 20; k++) begin cyc(1'b0, 1'b1, 1'b0); if (test_out != fref) ok = 0; end
        chk(ok, "R6 code 010 follows fref", ok, 1);
        t_sel = 3'b100; n_sel = 2'b00; ok = 1;
        for (int k = 0; k < 12; k++) begin cyc(1'b1, 1'b0, 1'b0); if (test_out != fout) ok = 0; end
        chk(ok, "R6 code 100 follows fout", ok, 1);
    endtask

    task automatic t_quarter;
        int rises;
        logic tp, fp;
        n_sel = 2'b11;
        t_sel = 3'b111;
        repeat (4) cyc(1'b1, 1'b0, 1'b0);
        tp = test_out;
        do cyc(1'b1, 1'b0, 1'b0); while (test_out == tp);
        for (int k = 0; k < 2; k++) begin
            tp = test_out; fp = fout; rises = 0;
            do begin
                cyc(1'b1, 1'b0, 1'b0);
                if (fout && !fp) rises++;
                fp = fout;
            end while (test_out == tp && rises < 20);
            chk(rises == 2, "R9 fout rises per quarter toggle", rises, 2);
        end
    endtask

    task automatic t_bypass;
        int n;
        logic f0;
        n_sel = 2'b11;
        t_sel = 3'b000;
        until_fout(1'b0, n);
        until_fout(1'b0, n);
        f0 = fout;
        t_sel = 3'b110;
        cyc(1'b0, 1'b0, 1'b1);
        chk(fout == f0, "R7 edge with select change not counted", fout, f0);
        cyc(1'b0, 1'b0, 1'b1);
        chk(fout != f0, "R7 next shift edge counted", fout, !f0);
        f0 = fout;
        repeat (4) cyc(1'b1, 1'b0, 1'b0);
        chk(fout == f0, "R7 vco ignored in bypass", fout, f0);
        n_sel = 2'b00;
        until_fout(1'b1, n);
        until_fout(1'b1, n);
        until_fout(1'b1, n);
        chk(n == 2, "R7 shift edges per half at code 00", n, 2);
        m_div = 9'd3;
        until_test(1'b1, n);
        until_test(1'b1, n);
        until_test(1'b1, n);
        chk(n == 6, "R7 shift edges between test pulses M=3", n, 6);
        t_sel = 3'b000;
        cyc(1'b0, 1'b0, 1'b0);
        f0 = fout;
        repeat (10) cyc(1'b0, 1'b0, 1'b1);
        chk(fout == f0, "R8 shift clock ignored outside bypass", fout, f0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_ratio(2'b00, 2);
        t_ratio(2'b01, 4);
        t_ratio(2'b10, 8);
        t_ratio(2'b11, 1);
        t_midchange();
        t_fref();
        t_fb(9'd5, 10);
        t_fb(9'd1, 2);
        t_fb(9'd0, 2);
        t_fb(9'd200, 400);
        t_mux();
        t_quarter();
        t_bypass();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule